// File: doc/BRIEF.md
# Write-Combining Posted Write Queue

This block sits between a host-side bus and a memory-side port and absorbs posted single-word writes. Each accepted write becomes one entry holding a destination address and one data word. Entries leave in arrival order as bursts: a start address, a word count and up to four data words.

While the queue is at least three quarters full, a background merge engine checks one slot pair per clock. When the first slot's address range ends exactly where the second slot's range begins, the two are folded into the first slot, which holds the lower address. The second slot is then unlinked from the middle of the list. The two slots need not be neighbours in queue order. A merge is refused when any other queued entry touches the combined address range, so the memory image the port produces matches the image the writes alone would produce. Storage is a linked list over sixteen slots, and the set of occupied slots doubles as the free list.

Top module: `wc_post_queue`

## Requirements
- R1: After reset the queue is empty: `out_valid` is 0, `occupancy` is 0 and `in_ready` is 1.
- R2: `in_ready` is 0 exactly when all 16 slots are occupied. `occupancy` counts the occupied slots and rises by at most one per clock.
- R3: Entries are presented in arrival order. `out_addr`, `out_cnt` and `out_data` describe the oldest entry and stay stable until `out_ready` takes it. Data word i sits at bits [32*i+31:32*i], and words at or above `out_cnt` read as zero.
- R4: A merge is considered only in a cycle that begins with `occupancy` of 12 or more. Below that level, occupancy never falls except through a dequeue.
- R5: A new write takes the lowest-numbered free slot. A pair counter, reset to 0, advances by one in every cycle that begins with occupancy of 12 or more. Its bits [7:4] select slot A and its bits [3:0] select slot B.
- R6: Slots A and B merge when all of these hold: the slots differ, both are occupied, neither is the oldest entry, B is not the newest entry, and A's start address plus A's count equals B's start address. The merged entry keeps A's position and A's address. B's words are appended after A's words, and B is removed from the queue.
- R7: A merge is refused if the combined count would exceed 4 words, so `out_cnt` is always between 1 and 4.
- R8: A merge is refused if any third occupied slot has an address range that overlaps the combined range of A and B.
- R9: Writing every dequeued burst into memory in order gives the same final memory contents as applying the accepted writes in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Write offered |
| in_ready | output | 1 | Queue can accept a write |
| in_addr | input | 16 | Word address of the write |
| in_data | input | 32 | Data word of the write |
| out_valid | output | 1 | A burst is available |
| out_ready | input | 1 | Memory side takes the burst |
| out_addr | output | 16 | First word address of the burst |
| out_cnt | output | 3 | Number of words, 1 to 4 |
| out_data | output | 128 | Burst words, word 0 in the low bits |
| occupancy | output | 5 | Number of occupied slots |

## Verification
Every result is due one clock after its cause. An accepted write appears in `occupancy` and `in_ready` after the next rising edge. The same holds for a dequeue, which moves the next entry onto the output fields, and for a merge, which removes one slot and widens the survivor. The bench keeps a behavioural model as slot arrays plus an ordered queue of slot numbers. At each falling edge it compares every output against the model, then drives new inputs and advances the model by one edge with those same inputs, so model and design always describe the same cycle. A final comparison of the two memory images covers the ordering rule.

// File: rtl/wc_post_queue.sv
module wc_post_queue #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int SLOTS = 16,
  parameter int WORDS = 4,
  parameter int THRESH = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [AW-1:0]       in_addr,
  input  logic [DW-1:0]       in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [AW-1:0]       out_addr,
  output logic [$clog2(WORDS+1)-1:0] out_cnt,
  output logic [WORDS*DW-1:0] out_data,
  output logic [$clog2(SLOTS+1)-1:0] occupancy
);
  localparam int SW = $clog2(SLOTS);
  localparam int CW = $clog2(WORDS+1);
  localparam int OW = $clog2(SLOTS+1);

  logic [SLOTS-1:0]       vld;
  logic [AW-1:0]          addr_q [SLOTS];
  logic [CW-1:0]          cnt_q  [SLOTS];
  logic [WORDS*DW-1:0]    dat_q  [SLOTS];
  logic [SW-1:0]          nxt_q  [SLOTS];
  logic [SW-1:0]          head, tail, fr, prv;
  logic [2*SW-1:0]        scan;
  logic [OW-1:0]          occ;
  logic                   clash, enq, deq, active, adj, fits, mrg, empty_next;
  logic [AW:0]            span_end;

  wire [SW-1:0] sa = scan[2*SW-1:SW];
  wire [SW-1:0] sb = scan[SW-1:0];

  always_comb begin
    occ = '0;
    fr = '0;
    prv = '0;
    clash = 1'b0;
    for (int k = SLOTS-1; k >= 0; k--) begin
      if (vld[k]) occ = occ + 1'b1;
      if (!vld[k]) fr = SW'(k);
      if (vld[k] && SW'(k) != tail && nxt_q[k] == sb) prv = SW'(k);
      if (vld[k] && SW'(k) != sa && SW'(k) != sb &&
          {1'b0, addr_q[k]} < span_end &&
          ({1'b0, addr_q[k]} + (AW+1)'(cnt_q[k])) > {1'b0, addr_q[sa]})
        clash = 1'b1;
    end
  end

  assign span_end   = {1'b0, addr_q[sa]} + (AW+1)'(cnt_q[sa]) + (AW+1)'(cnt_q[sb]);
  assign adj        = ({1'b0, addr_q[sa]} + (AW+1)'(cnt_q[sa])) == {1'b0, addr_q[sb]};
  assign fits       = ({1'b0, cnt_q[sa]} + {1'b0, cnt_q[sb]}) <= (CW+1)'(WORDS);
  assign active     = occ >= OW'(THRESH);
  assign mrg        = active && sa != sb && vld[sa] && vld[sb] && sa != head &&
                      sb != head && sb != tail && adj && fits && !clash;
  assign in_ready   = ~&vld;
  assign out_valid  = |vld;
  assign enq        = in_valid && in_ready;
  assign deq        = out_valid && out_ready;
  assign empty_next = (occ == '0) || (deq && occ == OW'(1));
  assign out_addr   = addr_q[head];
  assign out_cnt    = cnt_q[head];
  assign out_data   = dat_q[head];
  assign occupancy  = occ;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= '0;
      head <= '0;
      tail <= '0;
      scan <= '0;
    end else begin
      if (active) scan <= scan + 1'b1;
      if (deq) begin
        vld[head] <= 1'b0;
        head <= (mrg && prv == head) ? nxt_q[sb] : nxt_q[head];
      end
      if (mrg) begin
        vld[sb]    <= 1'b0;
        cnt_q[sa]  <= cnt_q[sa] + cnt_q[sb];
        dat_q[sa]  <= dat_q[sa] | (dat_q[sb] << (cnt_q[sa] * DW));
        nxt_q[prv] <= nxt_q[sb];
      end
      if (enq) begin
        vld[fr]    <= 1'b1;
        addr_q[fr] <= in_addr;
        cnt_q[fr]  <= CW'(1);
        dat_q[fr]  <= (WORDS*DW)'(in_data);
        if (empty_next) head <= fr;
        else nxt_q[tail] <= fr;
        tail <= fr;
      end
    end
  end

  assert_reset_empty_R1: assert property (@(posedge clk) rst |=> (!out_valid && occupancy == '0 && in_ready));
  assert_full_ready_R2: assert property (@(posedge clk) disable iff (rst) (occupancy == OW'(SLOTS)) |-> !in_ready);
  assert_occ_step_R2: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> occupancy <= $past(occupancy) + 1'b1);
  assert_hold_head_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_cnt) && $stable(out_data)));
  assert_no_merge_below_R4: assert property (@(posedge clk) disable iff (rst)
    (occupancy < OW'(THRESH) && !(out_valid && out_ready)) |=> occupancy >= $past(occupancy));
  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_cnt >= CW'(1) && out_cnt <= CW'(WORDS)));
endmodule

// File: tb/test_wc_post_queue.sv
module test_wc_post_queue;
  logic clk = 0, rst = 1;
  logic in_valid = 0, out_ready = 0;
  logic [15:0] in_addr = 0;
  logic [31:0] in_data = 0;
  logic in_ready, out_valid;
  logic [15:0] out_addr;
  logic [2:0] out_cnt;
  logic [127:0] out_data;
  logic [4:0] occupancy;

  always #5 clk = ~clk;

  wc_post_queue i_wc_post_queue (.clk, .rst, .in_valid, .in_ready, .in_addr, .in_data,
    .out_valid, .out_ready, .out_addr, .out_cnt, .out_data, .occupancy);

  int total = 0, bad = 0;
  bit m_vld [16];
  int m_addr [16];
  int m_cnt [16];
  int unsigned m_dat [16][4];
  int ord [$];
  int scan = 0;
  int unsigned ref_mem [int];
  int unsigned out_mem [int];
  int merges = 0, full_bursts = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2", "in_ready", in_ready, ord.size() < 16);
    chk("R2", "occupancy", occupancy, ord.size());
    chk("R3", "out_valid", out_valid, ord.size() > 0);
    if (ord.size() > 0) begin
      int h = ord[0];
      chk("R3", "out_addr", out_addr, m_addr[h]);
      chk("R6", "out_cnt", out_cnt, m_cnt[h]);
      for (int i = 0; i < 4; i++)
        chk("R6", "out_data word", out_data[32*i +: 32], (i < m_cnt[h]) ? m_dat[h][i] : 0);
    end
  endtask

  task automatic advance();
    bit enq, deq, act, mrg, clash;
    int f, sa, sb, h, t, e;
    enq = in_valid && ord.size() < 16;
    deq = out_ready && ord.size() > 0;
    act = ord.size() >= 12;
    f = 0;
    for (int k = 15; k >= 0; k--) if (!m_vld[k]) f = k;
    sa = scan / 16;
    sb = scan % 16;
    mrg = 0;
    if (act) begin
      h = ord[0];
      t = ord[ord.size()-1];
      e = m_addr[sa] + m_cnt[sa] + m_cnt[sb];
      clash = 0;
      for (int k = 0; k < 16; k++)
        if (m_vld[k] && k != sa && k != sb && m_addr[k] < e && m_addr[k] + m_cnt[k] > m_addr[sa])
          clash = 1;
      mrg = sa != sb && m_vld[sa] && m_vld[sb] && sa != h && sb != h && sb != t &&
            m_addr[sa] + m_cnt[sa] == m_addr[sb] && m_cnt[sa] + m_cnt[sb] <= 4 && !clash;
    end
    if (enq) ref_mem[int'(in_addr)] = in_data;
    if (deq) begin
      h = ord.pop_front();
      m_vld[h] = 0;
      for (int i = 0; i < m_cnt[h]; i++) out_mem[(m_addr[h] + i) % 65536] = m_dat[h][i];
      if (m_cnt[h] == 4) full_bursts++;
    end
    if (mrg) begin
      merges++;
      for (int i = 0; i < m_cnt[sb]; i++) m_dat[sa][m_cnt[sa] + i] = m_dat[sb][i];
      m_cnt[sa] += m_cnt[sb];
      m_vld[sb] = 0;
      for (int i = 0; i < ord.size(); i++) if (ord[i] == sb) begin ord.delete(i); break; end
    end
    if (enq) begin
      m_vld[f] = 1;
      m_addr[f] = in_addr;
      m_cnt[f] = 1;
      m_dat[f] = '{default: 0};
      m_dat[f][0] = in_data;
      ord.push_back(f);
    end
    if (act) scan = (scan + 1) % 256;
  endtask

  task automatic step(input bit v, input int a, input bit r);
    @(negedge clk);
    compare();
    in_valid = v;
    in_addr = 16'(a);
    in_data = $urandom;
    out_ready = r;
    advance();
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seq [16];
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", "out_valid after reset", out_valid, 0);
    chk("R1", "occupancy after reset", occupancy, 0);
    chk("R1", "in_ready after reset", in_ready, 1);
    // R5 R6: interleaved consecutive runs, held back so the engine works
    seq = '{16'h100, 16'h200, 16'h101, 16'h300, 16'h102, 16'h201, 16'h103, 16'h104,
            16'h301, 16'h202, 16'h105, 16'h400, 16'h302, 16'h203, 16'h500, 16'h501};
    foreach (seq[i]) step(1, seq[i], 0);
    for (int i = 0; i < 600; i++) step(1, 16'h600 + i, 0);
    for (int i = 0; i < 40; i++) step(0, 0, 1);
    chk("R6", "merges seen", merges > 0, 1);
    chk("R7", "four-word bursts seen", full_bursts > 0, 1);
    // R8: repeated addresses in a narrow window
    for (int i = 0; i < 3000; i++) step($urandom_range(0, 3) != 0, $urandom_range(0, 9), $urandom_range(0, 5) == 0);
    for (int i = 0; i < 40; i++) step(0, 0, 1);
    // R4 R9: mixed traffic over a wider window
    for (int i = 0; i < 6000; i++) step($urandom_range(0, 1), $urandom_range(0, 40), $urandom_range(0, 2) == 0);
    for (int i = 0; i < 40; i++) step(0, 0, 1);
    chk("R3", "drained", ord.size(), 0);
    chk("R9", "image size", out_mem.size(), ref_mem.size());
    foreach (ref_mem[k]) chk("R9", "memory word", out_mem.exists(k) ? out_mem[k] : 32'hdead_beef, ref_mem[k]);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule